// File: doc/BRIEF.md
# Decimal-Capable Add/Subtract/Compare Unit

This unit does the arithmetic behind add-with-carry, subtract-with-borrow and compare for an 8-bit accumulator machine of the early NMOS generation. It takes an accumulator value, an operand, a carry input, a decimal-mode bit and a 2-bit operation code. It returns an 8-bit result and the Negative, Overflow, Zero and Carry flags. Binary mode is plain two's-complement arithmetic. Decimal mode adjusts each 4-bit digit after the add or subtract.

Every operand value is handled, including digits above 9. In decimal addition the flags come from points inside the adjustment chain, not from the final result: Zero comes from the unadjusted binary sum, and Negative and Overflow come from the high digit after the low-digit fix and before the high-digit fix. Decimal subtraction adjusts only the result and keeps the binary flags. Compare always works in binary.

The result and flags pass through one output register stage, selected by `REG_OUT` (default 1). Outputs therefore appear one clock after the inputs that produced them.

Top module: `dec_arith_unit`

## Requirements
- R1: With `op_i`=0 (add) and `dec_i`=0, `res_o` = (A+M+Cin) mod 256, `c_o` = bit 8 of that sum, `n_o` = `res_o[7]`, `z_o` = (`res_o`==0), and `v_o` = 1 when A and M have equal sign bits and the sum's sign differs from A's.
- R2: With `op_i`=1 (subtract) and `dec_i`=0, `res_o` = (A−M−(1−Cin)) mod 256 and `c_o` = 1 when that difference is not negative. `n_o` is bit 7 of the difference, `z_o` = (difference mod 256 == 0), and `v_o` = 1 when A and M have different sign bits and the difference's sign differs from A's.
- R3: With `op_i`=2 or 3 (compare), `res_o` = A and `v_o` = `v_i`. `n_o`, `z_o` and `c_o` follow the R2 rules for A−M with Cin forced to 1. `dec_i` and `cin_i` have no effect.
- R4: Decimal add: L = A[3:0]+M[3:0]+Cin, and if L>9 then L+=6. H = A[7:4]+M[7:4]+(L>15). Then, if H>9, H+=6. `c_o` = (H>15) and `res_o` = {H[3:0], L[3:0]}.
- R5: Decimal add: `n_o` is bit 3 of H taken before the high fix. `v_o` = (H[3] XOR A[7]) AND NOT (A[7] XOR M[7]), also with H taken before the high fix.
- R6: Decimal add: `z_o` = ((A+M+Cin) mod 256 == 0), whatever the decimal result is.
- R7: Decimal subtract: L = A[3:0]−M[3:0]−(1−Cin), with borrow B = (L<0). If B, L−=6. H = A[7:4]−M[7:4]−B, and if H<0 then H−=6. `res_o` = {H[3:0], L[3:0]}.
- R8: Decimal subtract: `n_o`, `v_o`, `z_o` and `c_o` equal the binary-mode values of R2.
- R9: Digit values above 9 give exact results with no second carry out of a fix: 0x5F+0x0F (Cin=0) gives 0x64, and 0x5B+0x0F gives 0x60.
- R10: While `rst_n` is low, all outputs are 0. After reset, the outputs show the function of the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | 0 add, 1 subtract, 2/3 compare |
| dec_i | input | 1 | Decimal mode for add and subtract |
| cin_i | input | 1 | Carry in (inverted borrow for subtract) |
| v_i | input | 1 | Current overflow flag, passed through by compare |
| acc_i | input | 8 | Accumulator operand A |
| opd_i | input | 8 | Second operand M |
| res_o | output | 8 | Result |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |

## Verification
The unit holds no state between operations beyond the output register, so any internal error shows at the ports on the very next clock. A wrong low-digit fix or a wrong digit carry corrupts `res_o` and often `c_o`. Taking a flag from the wrong point in the chain shows up only for certain operand families, mostly digits above 9 and sums that straddle a digit or sign boundary. For that reason the exhaustive decimal-add sweep is the main check. Every vector is compared one cycle after it is applied.

// File: rtl/dec_arith_pkg.sv
package dec_arith_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_CMP = 2'd2,
    OP_CMX = 2'd3
  } op_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          n;
    logic          v;
    logic          z;
    logic          c;
  } out_t;
endpackage

// File: rtl/dec_bin_core.sv
module dec_bin_core
  import dec_arith_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          sub_i,
  input  logic          cin_i,
  output out_t          o
);
  logic [DW-1:0] b;
  logic [DW:0]   full;

  always_comb begin
    b      = sub_i ? ~m_i : m_i;
    full   = {1'b0, a_i} + {1'b0, b} + {{DW{1'b0}}, cin_i};
    o.res  = full[DW-1:0];
    o.c    = full[DW];
    o.n    = full[DW-1];
    o.z    = (full[DW-1:0] == '0);
    o.v    = ~(a_i[DW-1] ^ b[DW-1]) & (a_i[DW-1] ^ full[DW-1]);
  end
endmodule

// File: rtl/dec_digit_core.sv
module dec_digit_core
  import dec_arith_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          cin_i,
  output logic [DW-1:0] add_res_o,
  output logic          add_n_o,
  output logic          add_v_o,
  output logic          add_c_o,
  output logic [DW-1:0] sub_res_o
);
  localparam logic [NW+1:0] NINE = (NW+2)'(9);
  localparam logic [NW+1:0] SIX  = (NW+2)'(6);
  localparam logic [NW+1:0] MAXD = (NW+2)'((1 << NW) - 1);

  logic [NW+1:0] add_lo, add_lo_fix, add_hi, add_hi_fix;
  logic          lo_cy;
  logic [NW:0]   sub_lo, sub_hi;
  logic [NW-1:0] sub_lo_fix, sub_hi_fix;
  logic          lo_bw;

  // decimal add: low fix, carry taken from fixed low, flags before high fix
  always_comb begin
    add_lo     = {2'b00, a_i[NW-1:0]} + {2'b00, m_i[NW-1:0]} + {{(NW+1){1'b0}}, cin_i};
    add_lo_fix = (add_lo > NINE) ? add_lo + SIX : add_lo;
    lo_cy      = (add_lo_fix > MAXD);
    add_hi     = {2'b00, a_i[DW-1:NW]} + {2'b00, m_i[DW-1:NW]} + {{(NW+1){1'b0}}, lo_cy};
    add_n_o    = add_hi[NW-1];
    add_v_o    = (add_hi[NW-1] ^ a_i[DW-1]) & ~(a_i[DW-1] ^ m_i[DW-1]);
    add_hi_fix = (add_hi > NINE) ? add_hi + SIX : add_hi;
    add_c_o    = (add_hi_fix > MAXD);
    add_res_o  = {add_hi_fix[NW-1:0], add_lo_fix[NW-1:0]};
  end

  // decimal subtract: borrow is the sign of the unfixed low digit
  always_comb begin
    sub_lo     = {1'b0, a_i[NW-1:0]} - {1'b0, m_i[NW-1:0]} - {{NW{1'b0}}, ~cin_i};
    lo_bw      = sub_lo[NW];
    sub_lo_fix = lo_bw ? sub_lo[NW-1:0] - SIX[NW-1:0] : sub_lo[NW-1:0];
    sub_hi     = {1'b0, a_i[DW-1:NW]} - {1'b0, m_i[DW-1:NW]} - {{NW{1'b0}}, lo_bw};
    sub_hi_fix = sub_hi[NW] ? sub_hi[NW-1:0] - SIX[NW-1:0] : sub_hi[NW-1:0];
    sub_res_o  = {sub_hi_fix, sub_lo_fix};
  end
endmodule

// File: rtl/dec_arith_unit.sv
module dec_arith_unit
  import dec_arith_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op_i,
  input  logic          dec_i,
  input  logic          cin_i,
  input  logic          v_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opd_i,
  output logic [DW-1:0] res_o,
  output logic          n_o,
  output logic          v_o,
  output logic          z_o,
  output logic          c_o
);
  op_e           op;
  out_t          bin_o, cmp_o, nxt, cur;
  logic [DW-1:0] dadd_res, dsub_res;
  logic          dadd_n, dadd_v, dadd_c;

  assign op = op_e'(op_i);

  dec_bin_core u_arith (
    .a_i(acc_i), .m_i(opd_i), .sub_i(op == OP_SUB), .cin_i(cin_i), .o(bin_o)
  );

  dec_bin_core u_cmp (
    .a_i(acc_i), .m_i(opd_i), .sub_i(1'b1), .cin_i(1'b1), .o(cmp_o)
  );

  dec_digit_core u_digit (
    .a_i(acc_i), .m_i(opd_i), .cin_i(cin_i),
    .add_res_o(dadd_res), .add_n_o(dadd_n), .add_v_o(dadd_v), .add_c_o(dadd_c),
    .sub_res_o(dsub_res)
  );

  always_comb begin
    nxt = bin_o;
    unique case (op)
      OP_ADD: begin
        if (dec_i) begin
          nxt.res = dadd_res;
          nxt.n   = dadd_n;
          nxt.v   = dadd_v;
          nxt.c   = dadd_c;
        end
      end
      OP_SUB: begin
        if (dec_i) nxt.res = dsub_res;
      end
      default: begin
        nxt     = cmp_o;
        nxt.res = acc_i;
        nxt.v   = v_i;
      end
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      logic upd_en;
      logic primed;
      assign upd_en = 1'b1;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cur <= '0;
        else if (upd_en) cur <= nxt;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
      end

      AST_CMP_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i[1]) |-> (res_o == $past(acc_i)) && (v_o == $past(v_i))); // R3

      AST_ADD_ZERO_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(op_i) == 2'd0) |->
          z_o == (($past(acc_i) + $past(opd_i) + {{(DW-1){1'b0}}, $past(cin_i)}) == '0)); // R6

      AST_BIN_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(op_i) == 2'd0) && !$past(dec_i) |->
          res_o == ($past(acc_i) + $past(opd_i) + {{(DW-1){1'b0}}, $past(cin_i)})); // R1

      AST_SUB_CARRY_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(op_i) == 2'd1) |->
          c_o == ({1'b0, $past(acc_i)} >= ({1'b0, $past(opd_i)} + {{DW{1'b0}}, !$past(cin_i)}))); // R8

      AST_DEC_ADD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(op_i) == 2'd0) && $past(dec_i)
        && ($past(acc_i[NW-1:0]) <= 4'd9) && ($past(acc_i[DW-1:NW]) <= 4'd9)
        && ($past(opd_i[NW-1:0]) <= 4'd9) && ($past(opd_i[DW-1:NW]) <= 4'd9) |->
          (res_o[NW-1:0] <= 4'd9) && (res_o[DW-1:NW] <= 4'd9)); // R4
    end else begin : g_comb
      assign cur = nxt;
    end
  endgenerate

  assign res_o = cur.res;
  assign n_o   = cur.n;
  assign v_o   = cur.v;
  assign z_o   = cur.z;
  assign c_o   = cur.c;
endmodule

// File: tb/dec_arith_unit_tb.sv
module dec_arith_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic       dec_i = 1'b0, cin_i = 1'b0, v_i = 1'b0;
  logic [7:0] acc_i = 8'h00, opd_i = 8'h00;
  logic [7:0] res_o;
  logic       n_o, v_o, z_o, c_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dec_arith_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .dec_i(dec_i), .cin_i(cin_i),
    .v_i(v_i), .acc_i(acc_i), .opd_i(opd_i),
    .res_o(res_o), .n_o(n_o), .v_o(v_o), .z_o(z_o), .c_o(c_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d cycles expected<190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s op=%0d dec=%0d cin=%0d a=%02h m=%02h actual=%0h expected=%0h",
               tag, op_i, dec_i, cin_i, acc_i, opd_i, act, exp);
    end
  endtask

  // behavioural reference: {res, n, v, z, c}
  function automatic logic [11:0] model(input int op, input int dec, input int cin,
                                        input int vin, input int a, input int m);
    int r, n, v, z, c, lo, hi, br, d, s;
    if (op >= 2) begin
      d = a - m;
      r = a; v = vin; c = (d >= 0); z = ((d & 255) == 0); n = ((d & 128) != 0);
    end else if (op == 0) begin
      s = a + m + cin;
      z = ((s & 255) == 0);
      if (dec != 0) begin
        lo = (a & 15) + (m & 15) + cin;
        if (lo > 9) lo += 6;
        hi = (a >> 4) + (m >> 4) + ((lo > 15) ? 1 : 0);
        n = (hi >> 3) & 1;
        v = (((((hi << 4) ^ a) & 128) != 0) && (((a ^ m) & 128) == 0)) ? 1 : 0;
        if (hi > 9) hi += 6;
        c = (hi > 15);
        r = ((hi & 15) << 4) | (lo & 15);
      end else begin
        r = s & 255; c = (s > 255); n = (r >> 7) & 1;
        v = ((((a ^ m) & 128) == 0) && (((a ^ s) & 128) != 0)) ? 1 : 0;
      end
    end else begin
      d = a - m - (1 - cin);
      c = (d >= 0); z = ((d & 255) == 0); n = ((d & 128) != 0);
      v = ((((a ^ m) & 128) != 0) && (((a ^ d) & 128) != 0)) ? 1 : 0;
      if (dec != 0) begin
        lo = (a & 15) - (m & 15) - (1 - cin);
        br = (lo < 0) ? 1 : 0;
        if (br != 0) lo -= 6;
        hi = (a >> 4) - (m >> 4) - br;
        if (hi < 0) hi -= 6;
        r = ((hi & 15) << 4) | (lo & 15);
      end else r = d & 255;
    end
    return {r[7:0], n[0], v[0], z[0], c[0]};
  endfunction

  task automatic apply(input int op, input int dec, input int cin, input int vin,
                       input int a, input int m);
    logic [11:0] e;
    string tr, tn, tz, tc;
    bit bad;
    @(negedge clk);
    op_i = op[1:0]; dec_i = dec[0]; cin_i = cin[0]; v_i = vin[0];
    acc_i = a[7:0]; opd_i = m[7:0];
    e = model(op, dec, cin, vin, a, m);
    bad = ((a & 15) > 9) || ((a >> 4) > 9) || ((m & 15) > 9) || ((m >> 4) > 9);
    if (op >= 2)        begin tr = "R3"; tn = "R3"; tz = "R3"; tc = "R3"; end
    else if (op == 0 && dec != 0) begin
      tr = bad ? "R9" : "R4"; tn = "R5"; tz = "R6"; tc = bad ? "R9" : "R4";
    end else if (op == 0) begin tr = "R1"; tn = "R1"; tz = "R1"; tc = "R1"; end
    else if (dec != 0)  begin tr = "R7"; tn = "R8"; tz = "R8"; tc = "R8"; end
    else                begin tr = "R2"; tn = "R2"; tz = "R2"; tc = "R2"; end
    @(posedge clk); #1;
    chk(tr, int'(res_o), int'(e[11:4]));
    chk(tn, int'(n_o), int'(e[3]));
    chk(tn, int'(v_o), int'(e[2]));
    chk(tz, int'(z_o), int'(e[1]));
    chk(tc, int'(c_o), int'(e[0]));
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R10", int'({res_o, n_o, v_o, z_o, c_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R9 spot values
    apply(0, 1, 0, 0, 8'h5F, 8'h0F); chk("R9", int'(res_o), 8'h64);
    apply(0, 1, 0, 0, 8'h5B, 8'h0F); chk("R9", int'(res_o), 8'h60);
    apply(0, 1, 0, 0, 8'h59, 8'h01); chk("R4", int'(res_o), 8'h60);
    // R10: one-cycle latency, value tracks the newest inputs
    apply(0, 0, 0, 0, 8'h10, 8'h20); chk("R10", int'(res_o), 8'h30);

    // R4 R5 R6 R9: exhaustive decimal add
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m++)
        for (int c = 0; c < 2; c++)
          apply(0, 1, c, 0, a, m);

    // R7 R8: decimal subtract
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m += 11)
        for (int c = 0; c < 2; c++)
          apply(1, 1, c, 0, a, m);
    apply(1, 1, 1, 0, 8'h00, 8'h01);
    apply(1, 1, 0, 0, 8'h00, 8'hFF);

    // R1 R2: binary add and subtract
    for (int a = 0; a < 256; a += 5)
      for (int m = 0; m < 256; m += 7)
        for (int c = 0; c < 2; c++) begin
          apply(0, 0, c, 0, a, m);
          apply(1, 0, c, 0, a, m);
        end
    apply(0, 0, 0, 0, 8'h7F, 8'h01);
    apply(1, 0, 1, 0, 8'h80, 8'h01);
    apply(0, 0, 1, 0, 8'hFF, 8'h00);

    // R3: compare, decimal and carry ignored, codes 2 and 3
    for (int a = 0; a < 256; a += 5)
      for (int m = 0; m < 256; m += 7)
        apply(2 + ((a + m) & 1), (a >> 2) & 1, (m >> 1) & 1, (a ^ m) & 1, a, m);
    apply(2, 1, 0, 1, 8'h42, 8'h42);
    apply(3, 1, 0, 0, 8'h00, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule